// File: doc/BRIEF.md
# Command Ring Consumer with Opcode Screening

This block drains a circular command ring held in memory. Whenever the ring is switched on, holds unread entries and has no unacknowledged command error, it fetches the entry under its consumer pointer as one 16-byte read of four 32-bit words. It then checks the opcode in the low byte of word 0 against a sparse set of accepted values. Accepted commands are retired without further action: invalidations, prefetches and stall handling happen elsewhere. A sync command can also ask for a completion interrupt.

When a fetch returns an error, or when an opcode is not in the accepted set, the block writes a code into an error field of its consumer register. It also toggles its global command-error flag, which leaves that flag differing from the acknowledge bit that software owns, and pulses a global error interrupt. Fetching pauses until software makes the acknowledge bit equal to the flag again. Only one read is ever outstanding. The ring depth is a power of two, and the pointers carry one extra wrap bit above the index.

Top module: `cmdq_consumer`

## Requirements
- R1: After reset the consumer register reads 0, the error flag is 0, and no read request or interrupt is active.
- R2: No read is issued while `q_enable` is low. A fetch already outstanding still completes, and consumption continues when `q_enable` returns high.
- R3: A read is issued only when the consumer pointer differs from `prod_ptr`. Equal index with differing wrap bit means a full ring, which is drained completely.
- R4: No read is issued while `gerror_cmdq` differs from `gerrorn_cmdq`.
- R5: At most one read is outstanding. `rd_req` is a one-cycle pulse, and `rd_addr` equals `q_base + 16 * index`.
- R6: An accepted opcode (word 0 bits [7:0] in 0x01-0x07, 0x10-0x13, 0x18, 0x1A, 0x20-0x23, 0x28, 0x2A, 0x30, 0x40, 0x41, 0x44, 0x45, 0x46) advances the consumer pointer by one. The index sits in cons_reg bits [LOG2_DEPTH-1:0]. The wrap bit sits at bit LOG2_DEPTH and toggles when the index rolls over.
- R7: An opcode of 0x46 whose word 0 bit 12 is set pulses `irq_sync` for one cycle, in the cycle after the response. With bit 12 clear there is no pulse.
- R8: Any other opcode still advances the pointer. It writes code 1 into cons_reg bits [30:24], toggles `gerror_cmdq`, pulses `irq_gerror` and stops fetching.
- R9: A response with `rd_err` set leaves the pointer unchanged. It writes code 2 into bits [30:24], toggles `gerror_cmdq` and pulses `irq_gerror`.
- R10: Once the acknowledge bit matches the flag, fetching resumes. The error field keeps its last code, and an aborted entry is fetched again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| q_enable | input | 1 | Command ring enable |
| prod_ptr | input | LOG2_DEPTH+1 | Producer wrap bit and index |
| q_base | input | ADDR_W | Byte address of ring slot 0 |
| gerrorn_cmdq | input | 1 | Software acknowledge bit for the command error |
| rd_req | output | 1 | Read request pulse |
| rd_addr | output | ADDR_W | Byte address of the entry being fetched |
| rd_valid | input | 1 | Read response valid |
| rd_err | input | 1 | Read response carries an abort |
| rd_data | input | 4*WORD_W | Four command words, word 0 lowest |
| cons_reg | output | 32 | Consumer register: error code [30:24], wrap and index at the bottom |
| gerror_cmdq | output | 1 | Global command-error flag |
| irq_sync | output | 1 | Sync completion interrupt pulse |
| irq_gerror | output | 1 | Global error interrupt pulse |

## Verification
The ring is driven with response latencies from zero to three cycles, which separates a one-in-flight controller from one that would issue again before retiring. Sync entries with the interrupt bit set and with it clear show whether the completion field is actually decoded. Illegal opcodes and aborted fetches at different slots show whether the pointer is advanced or held in each case, what code lands in the error field, and that fetching stalls until acknowledge and then resumes. A run past the rollover point and a full-ring drain, where the indexes match but the wrap bits differ, tell full apart from empty; dropping the enable mid-stream checks the pause.

// File: rtl/cmdq_pkg.sv
package cmdq_pkg;

  localparam int OPC_W   = 8;
  localparam int CS_LSB  = 12;
  localparam int ERR_LSB = 24;
  localparam int ERR_W   = 7;

  localparam logic [OPC_W-1:0] OPC_SYNC = 8'h46;

  typedef enum logic [1:0] {
    CQ_ERR_NONE     = 2'd0,
    CQ_ERR_ILLEGAL  = 2'd1,
    CQ_ERR_ABORT    = 2'd2,
    CQ_ERR_ATC_SYNC = 2'd3
  } cq_err_e;

  typedef enum logic {
    FETCH_IDLE = 1'b0,
    FETCH_WAIT = 1'b1
  } fetch_st_e;

  // Sparse set of opcodes that are retired without error.
  function automatic logic opcode_legal(input logic [OPC_W-1:0] op);
    case (op)
      8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06, 8'h07,
      8'h10, 8'h11, 8'h12, 8'h13,
      8'h18, 8'h1A,
      8'h20, 8'h21, 8'h22, 8'h23,
      8'h28, 8'h2A,
      8'h30,
      8'h40, 8'h41,
      8'h44, 8'h45, 8'h46:  return 1'b1;
      default:              return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/cmdq_ring_ptr.sv
module cmdq_ring_ptr #(
  parameter  int LOG2_DEPTH = 4,
  localparam int PTR_W      = LOG2_DEPTH + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             advance,
  input  logic [PTR_W-1:0] prod_ptr,
  output logic [PTR_W-1:0] cons_ptr,
  output logic             ring_empty
);

  // Step index by one; the wrap bit flips when the index rolls over.
  function automatic logic [PTR_W-1:0] ptr_step(input logic [PTR_W-1:0] p);
    logic [LOG2_DEPTH-1:0] idx;
    logic                  wrap;
    idx  = p[LOG2_DEPTH-1:0] + LOG2_DEPTH'(1);
    wrap = p[LOG2_DEPTH] ^ (&p[LOG2_DEPTH-1:0]);
    return {wrap, idx};
  endfunction

  logic [PTR_W-1:0] cons_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cons_q <= '0;
    else if (advance) cons_q <= ptr_step(cons_q);
  end

  assign cons_ptr   = cons_q;
  assign ring_empty = (cons_q == prod_ptr);

endmodule

// File: rtl/cmdq_op_decode.sv
module cmdq_op_decode
  import cmdq_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic [WORD_W-1:0] word0,
  output logic              op_legal,
  output logic              op_sync,
  output logic              op_sync_irq
);

  logic [OPC_W-1:0] opcode;
  logic             cs_irq_bit;
  logic             unused_word0;

  assign opcode      = word0[OPC_W-1:0];
  assign cs_irq_bit  = word0[CS_LSB];
  assign op_legal    = opcode_legal(opcode);
  assign op_sync     = (opcode == OPC_SYNC);
  assign op_sync_irq = op_sync & cs_irq_bit;

  // Fields not needed for classification.
  assign unused_word0 = ^{word0[WORD_W-1:CS_LSB+1], word0[CS_LSB-1:OPC_W]};

endmodule

// File: rtl/cmdq_fetch_ctl.sv
module cmdq_fetch_ctl
  import cmdq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic can_start,
  input  logic rd_valid,
  output logic rd_req,
  output logic resp_take
);

  fetch_st_e state;

  assign rd_req    = (state == FETCH_IDLE) & can_start;
  assign resp_take = (state == FETCH_WAIT) & rd_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         state <= FETCH_IDLE;
    else if (rd_req)    state <= FETCH_WAIT;
    else if (resp_take) state <= FETCH_IDLE;
  end

endmodule

// File: rtl/cmdq_err_track.sv
module cmdq_err_track
  import cmdq_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    resp_take,
  input  logic    rd_err,
  input  logic    op_legal,
  input  logic    gerror_ack,
  output cq_err_e err_code,
  output logic    gerror_flag,
  output logic    irq_gerror,
  output logic    err_pending
);

  logic fault_abort;
  logic fault_illegal;

  assign fault_abort   = resp_take & rd_err;
  assign fault_illegal = resp_take & ~rd_err & ~op_legal;
  assign err_pending   = gerror_flag ^ gerror_ack;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_code    <= CQ_ERR_NONE;
      gerror_flag <= 1'b0;
      irq_gerror  <= 1'b0;
    end else begin
      irq_gerror <= fault_abort | fault_illegal;
      if (fault_abort | fault_illegal) begin
        err_code    <= fault_abort ? CQ_ERR_ABORT : CQ_ERR_ILLEGAL;
        gerror_flag <= ~gerror_flag;
      end
    end
  end

endmodule

// File: rtl/cmdq_consumer.sv
module cmdq_consumer
  import cmdq_pkg::*;
#(
  parameter  int LOG2_DEPTH = 4,
  parameter  int ADDR_W     = 32,
  parameter  int WORD_W     = 32,
  parameter  int CMD_WORDS  = 4,
  localparam int PTR_W      = LOG2_DEPTH + 1,
  localparam int DATA_W     = CMD_WORDS * WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              q_enable,
  input  logic [PTR_W-1:0]  prod_ptr,
  input  logic [ADDR_W-1:0] q_base,
  input  logic              gerrorn_cmdq,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_valid,
  input  logic              rd_err,
  input  logic [DATA_W-1:0] rd_data,
  output logic [31:0]       cons_reg,
  output logic              gerror_cmdq,
  output logic              irq_sync,
  output logic              irq_gerror
);

  localparam int SLOT_SHIFT = $clog2(DATA_W / 8);

  logic [PTR_W-1:0] cons_ptr;
  logic             ring_empty;
  logic             err_pending;
  logic             can_start;
  logic             resp_take;
  logic             advance;
  logic             op_legal;
  logic             op_sync;
  logic             op_sync_irq;
  logic             unused_payload;
  cq_err_e          err_code;

  assign can_start = q_enable & ~ring_empty & ~err_pending;
  assign advance   = resp_take & ~rd_err;

  cmdq_ring_ptr #(.LOG2_DEPTH(LOG2_DEPTH)) u_ring (
    .clk        (clk),
    .rst_n      (rst_n),
    .advance    (advance),
    .prod_ptr   (prod_ptr),
    .cons_ptr   (cons_ptr),
    .ring_empty (ring_empty)
  );

  cmdq_fetch_ctl u_fetch (
    .clk       (clk),
    .rst_n     (rst_n),
    .can_start (can_start),
    .rd_valid  (rd_valid),
    .rd_req    (rd_req),
    .resp_take (resp_take)
  );

  cmdq_op_decode #(.WORD_W(WORD_W)) u_dec (
    .word0       (rd_data[WORD_W-1:0]),
    .op_legal    (op_legal),
    .op_sync     (op_sync),
    .op_sync_irq (op_sync_irq)
  );

  cmdq_err_track u_err (
    .clk         (clk),
    .rst_n       (rst_n),
    .resp_take   (resp_take),
    .rd_err      (rd_err),
    .op_legal    (op_legal),
    .gerror_ack  (gerrorn_cmdq),
    .err_code    (err_code),
    .gerror_flag (gerror_cmdq),
    .irq_gerror  (irq_gerror),
    .err_pending (err_pending)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_sync <= 1'b0;
    else        irq_sync <= advance & op_sync_irq;
  end

  assign rd_addr = q_base + (ADDR_W'(cons_ptr[LOG2_DEPTH-1:0]) << SLOT_SHIFT);

  always_comb begin
    cons_reg                       = '0;
    cons_reg[PTR_W-1:0]            = cons_ptr;
    cons_reg[ERR_LSB +: ERR_W]     = ERR_W'(err_code);
  end

  // Payload words beyond word 0 are not needed by this block.
  assign unused_payload = ^{rd_data[DATA_W-1:WORD_W], op_sync};

endmodule

// File: rtl/cmdq_consumer_chk.sv
module cmdq_consumer_chk #(
  parameter int PTR_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             q_enable,
  input logic [PTR_W-1:0] prod_ptr,
  input logic [PTR_W-1:0] cons_ptr,
  input logic             rd_req,
  input logic             resp_take,
  input logic             rd_err,
  input logic             op_legal,
  input logic             op_sync_irq,
  input logic             gerror_cmdq,
  input logic             gerrorn_cmdq,
  input logic             irq_sync,
  input logic             irq_gerror,
  input logic [1:0]       err_code
);

  p_fetch_enabled_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> q_enable);

  p_fetch_nonempty_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> (cons_ptr != prod_ptr));

  p_fetch_no_pending_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> (gerror_cmdq == gerrorn_cmdq));

  p_single_flight_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> !rd_req);

  p_legal_advance_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_take && !rd_err && op_legal) |=> (cons_ptr != $past(cons_ptr)) && !irq_gerror);

  p_sync_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_take && !rd_err && op_sync_irq) |=> irq_sync);

  p_sync_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_sync |-> $past(resp_take));

  p_illegal_report_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_take && !rd_err && !op_legal) |=>
      (err_code == 2'd1) && irq_gerror && (gerror_cmdq != $past(gerror_cmdq)));

  p_abort_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_take && rd_err) |=> (err_code == 2'd2) && $stable(cons_ptr) && irq_gerror);

endmodule

bind cmdq_consumer cmdq_consumer_chk #(.PTR_W(PTR_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .q_enable     (q_enable),
  .prod_ptr     (prod_ptr),
  .cons_ptr     (cons_ptr),
  .rd_req       (rd_req),
  .resp_take    (resp_take),
  .rd_err       (rd_err),
  .op_legal     (op_legal),
  .op_sync_irq  (op_sync_irq),
  .gerror_cmdq  (gerror_cmdq),
  .gerrorn_cmdq (gerrorn_cmdq),
  .irq_sync     (irq_sync),
  .irq_gerror   (irq_gerror),
  .err_code     (err_code)
);

// File: tb/tb_cmdq_consumer.sv
`timescale 1ns/1ps
module tb_cmdq_consumer;

  localparam int LOG2_DEPTH = 4;
  localparam int DEPTH      = 16;
  localparam int PTR_W      = 5;
  localparam int ADDR_W     = 32;
  localparam int DATA_W     = 128;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic              q_enable     = 1'b0;
  logic [PTR_W-1:0]  prod_ptr     = '0;
  logic [ADDR_W-1:0] q_base       = 32'h0000_1000;
  logic              gerrorn_cmdq = 1'b0;
  logic              rd_req;
  logic [ADDR_W-1:0] rd_addr;
  logic              rd_valid = 1'b0;
  logic              rd_err   = 1'b0;
  logic [DATA_W-1:0] rd_data  = '0;
  logic [31:0]       cons_reg;
  logic              gerror_cmdq, irq_sync, irq_gerror;

  cmdq_consumer #(.LOG2_DEPTH(LOG2_DEPTH)) dut (
    .clk(clk), .rst_n(rst_n), .q_enable(q_enable), .prod_ptr(prod_ptr),
    .q_base(q_base), .gerrorn_cmdq(gerrorn_cmdq), .rd_req(rd_req),
    .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_err(rd_err), .rd_data(rd_data),
    .cons_reg(cons_reg), .gerror_cmdq(gerror_cmdq), .irq_sync(irq_sync),
    .irq_gerror(irq_gerror)
  );

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 0;

  task automatic check(input string tag, input longint act, input longint exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  int accepted [25] = '{8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06, 8'h07, 8'h10,
                        8'h11, 8'h12, 8'h13, 8'h18, 8'h1A, 8'h20, 8'h21, 8'h22,
                        8'h23, 8'h28, 8'h2A, 8'h30, 8'h40, 8'h41, 8'h44, 8'h45, 8'h46};

  function automatic bit accepted_op(input int op);
    foreach (accepted[k]) if (accepted[k] == op) return 1'b1;
    return 1'b0;
  endfunction

  // Memory model with programmable latency
  logic [31:0] mem_w0 [DEPTH];
  bit          mem_abort [DEPTH];
  int          lat = 1;
  logic        req_seen = 1'b0;
  logic [ADDR_W-1:0] addr_seen = '0;
  bit          rsp_busy = 0;
  int          rsp_cnt = 0;
  int          rsp_idx = 0;

  always @(posedge clk) begin
    req_seen  <= rd_req;
    addr_seen <= rd_addr;
  end

  always @(negedge clk) begin
    rd_valid = 1'b0;
    rd_err   = 1'b0;
    if (req_seen) begin
      rsp_busy = 1;
      rsp_cnt  = lat;
      rsp_idx  = int'((addr_seen - q_base) / 16) % DEPTH;
    end
    if (rsp_busy) begin
      if (rsp_cnt == 0) begin
        rd_valid = 1'b1;
        rd_err   = mem_abort[rsp_idx];
        rd_data  = {32'hA5A5_0003, 32'h0000_0000, 32'hFFFF_FFFF, mem_w0[rsp_idx]};
        rsp_busy = 0;
      end else begin
        rsp_cnt--;
      end
    end
  end

  // Behavioural reference model
  bit m_busy = 0;
  int m_cons = 0;
  int m_err  = 0;
  bit m_g    = 0;
  bit m_sirq = 0;
  bit m_girq = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_cons = 0; m_err = 0; m_g = 0; m_sirq = 0; m_girq = 0;
    end else begin
      m_sirq = 0;
      m_girq = 0;
      if (!m_busy) begin
        if (q_enable && (m_g == gerrorn_cmdq) && (m_cons != int'(prod_ptr))) m_busy = 1;
      end else if (rd_valid) begin
        m_busy = 0;
        if (rd_err) begin
          m_err = 2; m_g = !m_g; m_girq = 1;
        end else begin
          m_cons = (m_cons + 1) % (2 * DEPTH);
          if (!accepted_op(int'(rd_data[7:0]))) begin
            m_err = 1; m_g = !m_g; m_girq = 1;
          end else if (rd_data[7:0] == 8'h46 && rd_data[12]) begin
            m_sirq = 1;
          end
        end
      end
    end
  end

  bit cmp_on = 0;
  int sync_seen = 0;

  always @(negedge clk) begin
    #1;
    if (cmp_on && !finished) begin
      bit exp_req;
      exp_req = !m_busy && q_enable && (m_g == gerrorn_cmdq) && (m_cons != int'(prod_ptr));
      check("R5 rd_req", rd_req, exp_req);
      if (exp_req) check("R5 rd_addr", rd_addr, q_base + (m_cons % DEPTH) * 16);
      check("R6 cons_reg", cons_reg, (m_err << 24) | m_cons);
      check("R4 gerror_cmdq", gerror_cmdq, m_g);
      check("R7 irq_sync", irq_sync, m_sirq);
      check("R8 irq_gerror", irq_gerror, m_girq);
      if (irq_sync) sync_seen++;
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      mem_w0[i]    = 32'hBEEF_0F00 | 32'(accepted[(i * 3) % 25]);
      mem_abort[i] = 0;
    end
    mem_w0[1] = 32'h0000_1046;   // sync, interrupt requested
    mem_w0[2] = 32'h0000_2046;   // sync, no interrupt
    mem_w0[3] = 32'h0000_0008;   // not accepted

    idle(3);
    check("R1 cons_reg", cons_reg, 0);
    check("R1 rd_req", rd_req, 0);
    check("R1 gerror_cmdq", gerror_cmdq, 0);
    check("R1 irqs", {irq_sync, irq_gerror}, 0);
    rst_n = 1'b1;
    cmp_on = 1;

    prod_ptr = 5'd3;
    idle(20);
    check("R2 disabled holds", cons_reg, 0);

    lat = 2;
    q_enable = 1'b1;
    idle(40);
    check("R6 consumed three", cons_reg, 3);
    check("R7 one sync pulse", sync_seen, 1);

    prod_ptr = 5'd5;
    idle(40);
    check("R8 illegal code", cons_reg, 32'h0100_0004);
    check("R8 flag raised", gerror_cmdq, 1);
    idle(20);
    check("R4 stalled", cons_reg, 32'h0100_0004);

    lat = 0;
    gerrorn_cmdq = 1'b1;
    idle(30);
    check("R10 resumed", cons_reg, 32'h0100_0005);

    mem_abort[5] = 1;
    prod_ptr = 5'd7;
    idle(30);
    check("R9 abort holds", cons_reg, 32'h0200_0005);
    check("R9 flag toggled", gerror_cmdq, 0);

    mem_abort[5] = 0;
    mem_w0[3] = 32'h0000_0011;
    gerrorn_cmdq = 1'b0;
    idle(30);
    check("R10 refetch after abort", cons_reg, 32'h0200_0007);

    lat = 3;
    prod_ptr = 5'd18;
    idle(100);
    check("R6 wrap rollover", cons_reg, 32'h0200_0012);

    lat = 1;
    prod_ptr = 5'd2;
    idle(100);
    check("R3 full ring drained", cons_reg, 32'h0200_0002);

    mem_w0[2] = 32'h0000_0047;
    prod_ptr = 5'd3;
    idle(20);
    check("R8 illegal 0x47", cons_reg, 32'h0100_0003);

    q_enable = 1'b0;
    gerrorn_cmdq = 1'b1;
    prod_ptr = 5'd8;
    idle(20);
    check("R2 paused", cons_reg, 32'h0100_0003);
    q_enable = 1'b1;
    idle(40);
    check("R2 continued", cons_reg, 32'h0100_0008);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_checks++;
      n_errors++;
      $display("FAIL watchdog R1-wide timeout at %0t", $time);
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

endmodule